// File: doc/BRIEF.md
# I2C Bus Master with START-Byte Preamble

This block is a single-master I2C controller. It drives SCL and SDA through open-drain enables: a 1 on an enable pulls the wire low, and a 0 releases it. It reads SDA back through `sda_in`.

Software-side logic configures it through a small register port:

- a control word holding the enable bit;
- a target word holding a 10-bit address, a 10-bit mode flag and a two-bit special-command field;
- a divider word holding the SCL low and high phase lengths.

A write on the command port starts one transaction. The command carries a direction bit and a data byte. One transaction is a START, the address bytes, one data byte (written, or read and then not acknowledged by the master) and a STOP. With the START-byte command selected, the controller first sends the reserved byte 0000_0001. It follows that byte with a dummy ninth clock during which SDA stays released, then a repeated START, and only then the normal address phase.

The controller is one state machine with these states:

| State | What the bus does |
|---|---|
| IDLE | Both lines released |
| START | SDA low, SCL high |
| BIT_LO | SCL low, SDA set to the bit |
| BIT_HI | SCL high, SDA sampled |
| RS_LO | SCL low, SDA released |
| RS_HI | Both lines high |
| STOP_LO | Both lines low |
| STOP_HI | SCL high, SDA low |
| STOP_END | Both released |

Its transitions are:

- IDLE→START when a command is accepted.
- START→BIT_LO.
- BIT_LO→BIT_HI.
- BIT_HI→BIT_LO for the next bit, or for the next byte.
- BIT_HI→RS_LO after the preamble, or after the second address byte of a 10-bit read.
- BIT_HI→STOP_LO after the data byte, on a NACK, or when the block has been disabled.
- RS_LO→RS_HI→START.
- STOP_LO→STOP_HI→STOP_END→IDLE.

Each timed state lasts the low count (the LO states) or the high count (all the others) in clock cycles.

Top module: `i2c_preamble_master`

## Requirements
- R1: After reset, and in every cycle while `busy` is 0, both bus lines are released, and `busy`, `nack_err` and `drop_flag` are 0 after reset.
- R2: Register writes go to three offsets: offset 1 is the target word (bits 9:0 address, bit 10 selects 10-bit mode, bits 12:11 special command with 0 = none, 1 = general call, 2 = START byte) and offset 2 is the divider word (bits 7:0 low count, bits 15:8 high count). Writes to offsets 1 and 2 are ignored while the enable bit is 1. Offset 0, whose bit 0 is the enable bit, can always be written and clears `nack_err` and `drop_flag`.
- R3: A command write while disabled or busy is discarded: it causes no bus activity and sets `drop_flag`.
- R4: A 7-bit write sends START, then {addr[6:0],0}, then the data byte, each MSB first with a ninth acknowledge clock, then STOP. SDA changes while SCL is high only to form a START or a STOP.
- R5: A 7-bit read sends {addr[6:0],1}, then samples eight bits MSB first into `rd_data`, leaves SDA released on the ninth clock (NACK), and sends STOP.
- R6: With the START-byte command, the transaction opens with START, the byte 0x01 and a ninth clock with SDA released that never sets `nack_err`, then a repeated START and the normal address phase.
- R7: A general call sends address byte 0x00 followed by the data byte. The direction is forced to write whatever the command bit says.
- R8: A 10-bit write sends {11110, A9, A8, 0}, then A7..A0, then the data byte.
- R9: A 10-bit read sends the two write-form address bytes, a repeated START, {11110, A9, A8, 1}, and then the read byte.
- R10: A high SDA on the ninth clock of an address byte or a written byte sets `nack_err` and is followed directly by STOP.
- R11: Clearing the enable bit during a transaction lets the current byte finish, then sends STOP and returns to IDLE.
- R12: Each SCL high phase of a bit lasts exactly the high count in cycles, and each SCL low phase lasts exactly the low count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 2*DIV_W | Register write data |
| cmd_valid | input | 1 | Command write strobe |
| cmd_read | input | 1 | Direction of the command: 1 = read |
| cmd_data | input | 8 | Byte to write |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction in progress |
| rd_data | output | 8 | Last byte read |
| nack_err | output | 1 | Missing acknowledge seen (sticky) |
| drop_flag | output | 1 | A command was discarded (sticky) |

## Verification
The embedded properties check these rules on every cycle:

- SDA moves under a released SCL only in the START and STOP_END states.
- The configuration holds steady while the block is enabled.
- A discarded command raises `drop_flag`.
- The dummy acknowledge of the preamble never raises `nack_err`.
- Every `nack_err` leads straight into the STOP sequence.

The byte order of each mode, the exact phase lengths, the read data, the forced write of a general call, and the graceful stop after a disable are visible only in the bench's scenarios. There, a bus monitor and a slave model decode the wires and compare them with the event sequence expected for each mode.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_BIT_LO, S_BIT_HI, S_RS_LO, S_RS_HI,
        S_STOP_LO, S_STOP_HI, S_STOP_END
    } bus_state_e;

    typedef enum logic [2:0] {
        G_PRE, G_ADDR1, G_ADDR2, G_ADDR3, G_DATA
    } stage_e;

    typedef enum logic [1:0] {
        SP_NONE  = 2'd0,
        SP_GCALL = 2'd1,
        SP_SBYTE = 2'd2,
        SP_RSVD  = 2'd3
    } special_e;

    localparam int          TGT_W      = 10;
    localparam int          TEN_POS    = 10;
    localparam int          SPEC_LSB   = 11;
    localparam int          BYTE_W     = 8;
    localparam int          IDX_W      = 4;
    localparam logic [3:0]  ACK_SLOT   = 4'd8;
    localparam logic [7:0]  SBYTE_VAL  = 8'h01;
    localparam logic [7:0]  GCALL_VAL  = 8'h00;
    localparam logic [4:0]  TEN_PREFIX = 5'b11110;
    localparam logic [1:0]  OFS_CTRL   = 2'd0;
    localparam logic [1:0]  OFS_TARGET = 2'd1;
    localparam logic [1:0]  OFS_DIV    = 2'd2;

endpackage

// File: rtl/i2cpm_cfg.sv
module i2cpm_cfg
    import i2cpm_pkg::*;
#(
    parameter int DIV_W = 8,
    localparam int REG_W = 2 * DIV_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic                 en,
    output logic [TGT_W-1:0]     tgt,
    output logic                 ten,
    output special_e             spec,
    output logic [DIV_W-1:0]     lo_cnt,
    output logic [DIV_W-1:0]     hi_cnt,
    output logic                 ctrl_wr
);

    assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            tgt    <= '0;
            ten    <= 1'b0;
            spec   <= SP_NONE;
            lo_cnt <= DIV_W'(4);
            hi_cnt <= DIV_W'(4);
        end else begin
            if (ctrl_wr) begin
                en <= reg_wdata[0];
            end
            if (reg_wr && !en && reg_addr == OFS_TARGET) begin
                tgt  <= reg_wdata[TGT_W-1:0];
                ten  <= reg_wdata[TEN_POS];
                spec <= special_e'(reg_wdata[SPEC_LSB+1:SPEC_LSB]);
            end
            if (reg_wr && !en && reg_addr == OFS_DIV) begin
                lo_cnt <= reg_wdata[DIV_W-1:0];
                hi_cnt <= reg_wdata[REG_W-1:DIV_W];
            end
        end
    end

    // Configuration frozen while enabled (R2)
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> ($stable(tgt) && $stable(ten) && $stable(spec)
                       && $stable(lo_cnt) && $stable(hi_cnt)));

endmodule

// File: rtl/i2cpm_phase.sv
module i2cpm_phase #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] limit,
    output logic             done
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign done = ({1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1}) >= {1'b0, limit};

endmodule

// File: rtl/i2c_preamble_master.sv
module i2c_preamble_master
    import i2cpm_pkg::*;
#(
    parameter int DIV_W = 8,
    localparam int REG_W = 2 * DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic [BYTE_W-1:0] rd_data,
    output logic              nack_err,
    output logic              drop_flag
);

    logic             en, ten, ctrl_wr;
    logic [TGT_W-1:0] tgt;
    special_e         spec;
    logic [DIV_W-1:0] lo_cnt, hi_cnt, ph_limit;

    i2cpm_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .en(en), .tgt(tgt), .ten(ten), .spec(spec),
        .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .ctrl_wr(ctrl_wr)
    );

    bus_state_e        state, state_n;
    stage_e            stage, stage_n;
    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] rx_sh, wd_q, tx_byte;
    logic              rd_q, ten_q, ph_done, ph_restart;
    logic              accept, byte_end, ack_bad, is_rd_data;

    assign accept     = (state == S_IDLE) && cmd_valid && en;
    assign is_rd_data = (stage == G_DATA) && rd_q;
    assign byte_end   = (state == S_BIT_HI) && ph_done && (bit_idx == ACK_SLOT);
    assign ack_bad    = sda_in && (stage != G_PRE) && !is_rd_data;
    assign ph_restart = ph_done || (state == S_IDLE);
    assign ph_limit   = (state == S_BIT_LO || state == S_RS_LO || state == S_STOP_LO)
                        ? lo_cnt : hi_cnt;

    i2cpm_phase #(.DIV_W(DIV_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .restart(ph_restart),
        .limit(ph_limit), .done(ph_done)
    );

    always_comb begin
        unique case (stage)
            G_PRE:   tx_byte = SBYTE_VAL;
            G_ADDR1: tx_byte = ten_q ? {TEN_PREFIX, tgt[9:8], 1'b0}
                             : (spec == SP_GCALL) ? GCALL_VAL : {tgt[6:0], rd_q};
            G_ADDR2: tx_byte = tgt[7:0];
            G_ADDR3: tx_byte = {TEN_PREFIX, tgt[9:8], 1'b1};
            G_DATA:  tx_byte = rd_q ? 8'hFF : wd_q;
            default: tx_byte = 8'hFF;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        stage_n = stage;
        unique case (state)
            S_IDLE: if (accept) begin
                state_n = S_START;
                stage_n = (spec == SP_SBYTE) ? G_PRE : G_ADDR1;
            end
            S_START:  if (ph_done) state_n = S_BIT_LO;
            S_BIT_LO: if (ph_done) state_n = S_BIT_HI;
            S_BIT_HI: if (ph_done) begin
                if (bit_idx != ACK_SLOT) begin
                    state_n = S_BIT_LO;
                end else if (stage == G_PRE) begin
                    state_n = en ? S_RS_LO : S_STOP_LO;
                    stage_n = G_ADDR1;
                end else if (ack_bad || !en || stage == G_DATA) begin
                    state_n = S_STOP_LO;
                end else if (stage == G_ADDR1) begin
                    state_n = S_BIT_LO;
                    stage_n = ten_q ? G_ADDR2 : G_DATA;
                end else if (stage == G_ADDR2 && rd_q) begin
                    state_n = S_RS_LO;
                    stage_n = G_ADDR3;
                end else begin
                    state_n = S_BIT_LO;
                    stage_n = G_DATA;
                end
            end
            S_RS_LO:    if (ph_done) state_n = S_RS_HI;
            S_RS_HI:    if (ph_done) state_n = S_START;
            S_STOP_LO:  if (ph_done) state_n = S_STOP_HI;
            S_STOP_HI:  if (ph_done) state_n = S_STOP_END;
            S_STOP_END: if (ph_done) state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            stage <= G_ADDR1;
        end else begin
            state <= state_n;
            stage <= stage_n;
        end
    end

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx   <= '0;
            rx_sh     <= '0;
            wd_q      <= '0;
            rd_q      <= 1'b0;
            ten_q     <= 1'b0;
            rd_data   <= '0;
            nack_err  <= 1'b0;
            drop_flag <= 1'b0;
        end else begin
            if (accept) begin
                rd_q  <= cmd_read && (spec != SP_GCALL);
                ten_q <= ten && (spec != SP_GCALL);
                wd_q  <= cmd_data;
            end
            if (state != S_BIT_LO && state != S_BIT_HI) begin
                bit_idx <= '0;
            end else if (state == S_BIT_HI && ph_done) begin
                bit_idx <= (bit_idx == ACK_SLOT) ? '0 : bit_idx + 1'b1;
            end
            if (state == S_BIT_HI && ph_done && bit_idx != ACK_SLOT) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
            end
            if (byte_end && is_rd_data) rd_data <= rx_sh;
            if (ctrl_wr || accept)      nack_err <= 1'b0;
            if (byte_end && ack_bad)    nack_err <= 1'b1;
            if (ctrl_wr)                drop_flag <= 1'b0;
            if (cmd_valid && (!en || state != S_IDLE)) drop_flag <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            S_IDLE, S_RS_HI, S_STOP_END: ;
            S_START:   sda_oe = 1'b1;
            S_RS_LO:   scl_oe = 1'b1;
            S_STOP_LO: begin scl_oe = 1'b1; sda_oe = 1'b1; end
            S_STOP_HI: sda_oe = 1'b1;
            S_BIT_LO, S_BIT_HI: begin
                scl_oe = (state == S_BIT_LO);
                sda_oe = (bit_idx != ACK_SLOT) && !is_rd_data
                         && !tx_byte[3'd7 - bit_idx[2:0]];
            end
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);

    // SDA moves under a released SCL only to form START or STOP (R4)
    assert_sda_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
        |-> (state == S_START || state == S_STOP_END));

    // A discarded command raises the drop flag (R3)
    assert_drop_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !en) |=> drop_flag);

    // The dummy acknowledge of the preamble never flags an error (R6)
    assert_pre_no_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BIT_HI && stage == G_PRE && ph_done && bit_idx == ACK_SLOT)
        |=> (nack_err == $past(nack_err)));

    // A new missing-acknowledge error leads straight into STOP (R10)
    assert_nack_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_err) |-> (state == S_STOP_LO));

endmodule

// File: tb/tb_i2c_preamble_master.sv
`timescale 1ns/1ps
module tb_i2c_preamble_master;

    localparam int LO = 5;
    localparam int HI = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        scl_oe, sda_oe, busy, nack_err, drop_flag;
    logic [7:0]  rd_data;
    logic        slave_low = 1'b0;
    logic        scl_l, sda_l;

    always #2 clk = ~clk;

    assign scl_l = ~scl_oe;
    assign sda_l = ~(sda_oe | slave_low);

    i2c_preamble_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_data(cmd_data), .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .rd_data(rd_data), .nack_err(nack_err), .drop_flag(drop_flag)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    int    exp_q[$];
    bit    ack_q[$];
    bit    rdf_q[$];
    logic [7:0] rd_val = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected bus events: 256 = START, 257 = STOP, 0..255 = byte
    task automatic e_s();
        exp_q.push_back(256);
    endtask
    task automatic e_p();
        exp_q.push_back(257);
    endtask
    task automatic e_b(input int v, input bit ack, input bit rdb);
        exp_q.push_back(v);
        ack_q.push_back(ack);
        rdf_q.push_back(rdb);
    endtask

    task automatic ev_check(input int v);
        if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, v, -1);
        end else begin
            chk(exp_q[0] == v, cur_req, v, exp_q[0]);
            void'(exp_q.pop_front());
        end
    endtask

    // Bus monitor and slave model, evaluated on every clock
    int   bitcnt = 0, hi_run = 0, lo_run = 0;
    bit   saw_start = 1'b0, scl_p = 1'b1, sda_p = 1'b1;
    logic [7:0] shreg = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) chk(scl_l && sda_l, "R1", {30'd0, scl_l, sda_l}, 3);
            if (scl_p && scl_l && sda_p && !sda_l) begin
                ev_check(256); bitcnt = 0; saw_start = 1'b1;
            end
            if (scl_p && scl_l && !sda_p && sda_l) begin
                ev_check(257); bitcnt = 0;
            end
            if (!scl_p && scl_l) begin
                chk(lo_run == LO, "R12", lo_run, LO);
                hi_run = 0;
                if (bitcnt < 8) begin
                    shreg = {shreg[6:0], sda_l};
                    bitcnt++;
                    if (bitcnt == 8) ev_check(int'(shreg));
                end else begin
                    bitcnt = 0;
                    if (ack_q.size() > 0) void'(ack_q.pop_front());
                    if (rdf_q.size() > 0) void'(rdf_q.pop_front());
                end
            end
            if (scl_p && !scl_l) begin
                if (!saw_start) chk(hi_run == HI, "R12", hi_run, HI);
                saw_start = 1'b0;
                lo_run = 0;
            end
            if (scl_l) hi_run++; else lo_run++;
            if (!scl_l) begin
                if (ack_q.size() == 0)  slave_low <= 1'b0;
                else if (bitcnt == 8)   slave_low <= ack_q[0];
                else                    slave_low <= rdf_q[0] && !rd_val[7-bitcnt];
            end
            scl_p = scl_l;
            sda_p = sda_l;
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic do_cmd(input bit rd, input logic [7:0] d);
        @(negedge clk); cmd_valid = 1'b1; cmd_read = rd; cmd_data = d;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic finish_xfer();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
        exp_q.delete(); ack_q.delete(); rdf_q.delete();
    endtask

    function automatic logic [15:0] tgtw(input int sp, input bit tb, input int a);
        return {3'b000, 2'(sp), tb, 10'(a)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1", {scl_oe, sda_oe}, 0);
        chk(!busy, "R1", busy, 0);
        chk(!nack_err && !drop_flag, "R1", {nack_err, drop_flag}, 0);

        wr_reg(2'd2, {8'(HI), 8'(LO)});
        wr_reg(2'd1, tgtw(0, 0, 'h50));

        // R3: command while disabled is discarded
        cur_req = "R3";
        do_cmd(1'b0, 8'h12);
        repeat (40) @(negedge clk);
        chk(drop_flag, "R3", drop_flag, 1);
        chk(!busy, "R3", busy, 0);
        wr_reg(2'd0, 16'h0001);
        chk(!drop_flag, "R3", drop_flag, 0);

        // R4: 7-bit write, plus a command while busy (R3)
        cur_req = "R4";
        e_s(); e_b('hA0, 1, 0); e_b('hA5, 1, 0); e_p();
        do_cmd(1'b0, 8'hA5);
        repeat (10) @(negedge clk);
        do_cmd(1'b1, 8'h77);
        finish_xfer();
        chk(drop_flag, "R3", drop_flag, 1);
        chk(!nack_err, "R4", nack_err, 0);

        // R5: 7-bit read
        cur_req = "R5";
        rd_val = 8'h3C;
        e_s(); e_b('hA1, 1, 0); e_b('h3C, 0, 1); e_p();
        do_cmd(1'b1, 8'h00);
        finish_xfer();
        chk(rd_data == 8'h3C, "R5", rd_data, 'h3C);

        // R2: writes while enabled are ignored
        cur_req = "R2";
        wr_reg(2'd1, tgtw(0, 0, 'h11));
        wr_reg(2'd2, 16'h0909);
        e_s(); e_b('hA0, 1, 0); e_b('h0F, 1, 0); e_p();
        do_cmd(1'b0, 8'h0F);
        finish_xfer();

        // R6: START-byte preamble
        cur_req = "R6";
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, tgtw(2, 0, 'h50));
        wr_reg(2'd0, 16'h0001);
        e_s(); e_b('h01, 0, 0); e_s(); e_b('hA0, 1, 0); e_b('hC3, 1, 0); e_p();
        do_cmd(1'b0, 8'hC3);
        finish_xfer();
        chk(!nack_err, "R6", nack_err, 0);

        // R7: general call, read bit forced to write
        cur_req = "R7";
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, tgtw(1, 0, 'h55));
        wr_reg(2'd0, 16'h0001);
        e_s(); e_b('h00, 1, 0); e_b('h5A, 1, 0); e_p();
        do_cmd(1'b1, 8'h5A);
        finish_xfer();

        // R8: 10-bit write
        cur_req = "R8";
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, tgtw(0, 1, 'h2A7));
        wr_reg(2'd0, 16'h0001);
        e_s(); e_b('hF4, 1, 0); e_b('hA7, 1, 0); e_b('h99, 1, 0); e_p();
        do_cmd(1'b0, 8'h99);
        finish_xfer();

        // R9: 10-bit read
        cur_req = "R9";
        rd_val = 8'h81;
        e_s(); e_b('hF4, 1, 0); e_b('hA7, 1, 0); e_s(); e_b('hF5, 1, 0);
        e_b('h81, 0, 1); e_p();
        do_cmd(1'b1, 8'h00);
        finish_xfer();
        chk(rd_data == 8'h81, "R9", rd_data, 'h81);

        // R10: address not acknowledged
        cur_req = "R10";
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, tgtw(0, 0, 'h50));
        wr_reg(2'd0, 16'h0001);
        e_s(); e_b('hA0, 0, 0); e_p();
        do_cmd(1'b0, 8'h44);
        finish_xfer();
        chk(nack_err, "R10", nack_err, 1);

        // R11: disable during the address byte
        cur_req = "R11";
        wr_reg(2'd0, 16'h0001);
        e_s(); e_b('hA0, 1, 0); e_p();
        do_cmd(1'b0, 8'h66);
        repeat (20) @(negedge clk);
        wr_reg(2'd0, 16'h0000);
        chk(busy, "R11", busy, 1);
        finish_xfer();
        chk(!nack_err, "R11", nack_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule